// File: doc/BRIEF.md
# Masked Six-Event Interrupt Controller

This block gathers six FIFO and link conditions into a sticky raw status vector, blocks selected events with a per-event mask and drives a single registered interrupt line from whatever passes the mask. Each event input is a level. The raw bit for an event is set on the rising edge of its level. After that the bit holds until software reads the raw status. That read clears the vector, and events that rise in the same cycle as the read survive it.

The mask is a read-write vector. A mask bit of 1 blocks its event and a mask bit of 0 lets it through. The mask starts with every event blocked. Software reads the mask and the masked status together as one word: the mask sits in the low half and the masked status in the high half. The interrupt output is the OR of the masked status, delayed by one register stage.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, raw status is 0x01 (only the FIFO-empty event set), the mask is 0x3F (all events blocked), the masked status is 0 and the interrupt output is low.
- R2: A 0-to-1 transition on an event level sets its raw bit at the next clock edge. A level that stays high does not set the bit again after it has been cleared. Edge detection starts from a baseline where only the empty level (bit 0) is high.
- R3: Event bit positions are fixed: bit 0 FIFO empty, bit 1 FIFO full, bit 2 underflow, bit 3 overflow, bit 4 not empty during a direct-access read, bit 5 device-side receive done.
- R4: A cycle with the raw-read strobe high clears every raw bit at the next clock edge, except the bits whose event rises in that same cycle.
- R5: An event that rises in the same cycle as a clearing read is set in raw status after the read and is not lost.
- R6: The high half of the mask word (bits 11:6) equals raw status AND NOT mask. It holds no bit whose mask bit is 1 and no bit that is clear in raw status.
- R7: A mask write loads the written value into mask word bits 5:0 at the next clock edge. Without a write, the mask holds its value.
- R8: The interrupt output equals the OR of the masked status bits of the previous cycle.
- R9: Raw bits are sticky: without a read they stay set when the level falls, and writing the mask does not change raw status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_lvl_i | input | NUM_EVT | Event condition levels, positions as in R3 |
| raw_rd_i | input | 1 | Raw status read strobe; clears raw status |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | NUM_EVT | Value written to the mask |
| raw_o | output | NUM_EVT | Raw sticky event status |
| mask_word_o | output | 2*NUM_EVT | {masked status, mask} |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the event levels, the read strobe and the mask write inputs are driven to known values from reset onward and change only between clock edges. They also assume that the levels held during reset match the baseline, with only the empty level high. The bench holds the levels at 0x01 through reset and drives every input at the falling edge. It runs a free-running stimulus where reads and mask writes can coincide with rising edges, so the same-cycle cases are reached. An exhaustive sweep over all 64 mask values covers every polarity combination.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int unsigned EVT_COUNT   = 6;
    localparam int unsigned EVT_EMPTY   = 0;
    localparam int unsigned EVT_FULL    = 1;
    localparam int unsigned EVT_UNDER   = 2;
    localparam int unsigned EVT_OVER    = 3;
    localparam int unsigned EVT_DA_NEMP = 4;
    localparam int unsigned EVT_RX_DONE = 5;
endpackage

// File: rtl/evt_irq_edge.sv
module evt_irq_edge #(
    parameter int unsigned N       = 6,
    parameter int unsigned RST_LVL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        rise_o    = lvl_i & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.prev <= N'(RST_LVL);
        else        st_q      <= st_d;
    end
endmodule

// File: rtl/evt_irq_stat.sv
module evt_irq_stat #(
    parameter int unsigned N       = 6,
    parameter int unsigned RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic         clr_i,
    output logic [N-1:0] raw_o
);
    typedef struct packed {
        logic [N-1:0] raw;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.raw = '0;
        // set wins over clear so a coincident event survives the read
        st_d.raw = st_d.raw | rise_i;
        raw_o    = st_q.raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.raw <= N'(RST_VAL);
        else        st_q     <= st_d;
    end
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
    parameter int unsigned N        = 6,
    parameter int unsigned RST_MASK = 63
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] masked_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] mask;
        logic         irq;
    } mask_st_t;

    mask_st_t     st_d, st_q;
    logic [N-1:0] pass;

    always_comb begin
        st_d = st_q;
        pass = raw_i & ~st_q.mask;
        if (wr_i) st_d.mask = wdata_i;
        st_d.irq = |pass;
        mask_o   = st_q.mask;
        masked_o = pass;
        irq_o    = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= N'(RST_MASK);
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int unsigned NUM_EVT  = evt_irq_pkg::EVT_COUNT,
    parameter int unsigned RAW_RST  = 1,
    parameter int unsigned MASK_RST = (1 << NUM_EVT) - 1,
    localparam int unsigned WORD_W  = 2 * NUM_EVT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_lvl_i,
    input  logic               raw_rd_i,
    input  logic               mask_wr_i,
    input  logic [NUM_EVT-1:0] mask_wdata_i,
    output logic [NUM_EVT-1:0] raw_o,
    output logic [WORD_W-1:0]  mask_word_o,
    output logic               irq_o
);
    logic [NUM_EVT-1:0] rise;
    logic [NUM_EVT-1:0] raw;
    logic [NUM_EVT-1:0] mask;
    logic [NUM_EVT-1:0] masked;

    evt_irq_edge #(.N(NUM_EVT), .RST_LVL(RAW_RST)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (evt_lvl_i),
        .rise_o (rise)
    );

    evt_irq_stat #(.N(NUM_EVT), .RST_VAL(RAW_RST)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise),
        .clr_i  (raw_rd_i),
        .raw_o  (raw)
    );

    evt_irq_mask #(.N(NUM_EVT), .RST_MASK(MASK_RST)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (mask_wr_i),
        .wdata_i  (mask_wdata_i),
        .raw_i    (raw),
        .mask_o   (mask),
        .masked_o (masked),
        .irq_o    (irq_o)
    );

    assign raw_o       = raw;
    assign mask_word_o = {masked, mask};
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
    parameter int unsigned NUM_EVT = 6,
    localparam int unsigned WORD_W = 2 * NUM_EVT
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_lvl_i,
    input logic               raw_rd_i,
    input logic               mask_wr_i,
    input logic [NUM_EVT-1:0] mask_wdata_i,
    input logic [NUM_EVT-1:0] raw_o,
    input logic [WORD_W-1:0]  mask_word_o,
    input logic               irq_o
);
    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_rd_i |=> ((raw_o & ~$past(evt_lvl_i)) == '0));

    // R9
    sticky_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_rd_i |=> ((raw_o & $past(raw_o)) == $past(raw_o)));

    // R6
    masked_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_word_o[WORD_W-1:NUM_EVT] & mask_word_o[NUM_EVT-1:0]) == '0);

    // R6
    masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_word_o[WORD_W-1:NUM_EVT] & ~raw_o) == '0);

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (mask_word_o[NUM_EVT-1:0] == $past(mask_wdata_i)));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(mask_word_o[NUM_EVT-1:0]));

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|$past(mask_word_o[WORD_W-1:NUM_EVT])));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_lvl_i    (evt_lvl_i),
    .raw_rd_i     (raw_rd_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .raw_o        (raw_o),
    .mask_word_o  (mask_word_o),
    .irq_o        (irq_o)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_lvl_i = 6'h01;
    logic         raw_rd_i = 1'b0;
    logic         mask_wr_i = 1'b0;
    logic [N-1:0] mask_wdata_i = '0;
    logic [N-1:0] raw_o;
    logic [2*N-1:0] mask_word_o;
    logic         irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    logic [N-1:0] m_raw  = 6'h01;
    logic [N-1:0] m_mask = 6'h3F;
    logic [N-1:0] m_prev = 6'h01;
    logic         m_irq  = 1'b0;

    always #10 clk = ~clk;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_lvl_i    (evt_lvl_i),
        .raw_rd_i     (raw_rd_i),
        .mask_wr_i    (mask_wr_i),
        .mask_wdata_i (mask_wdata_i),
        .raw_o        (raw_o),
        .mask_word_o  (mask_word_o),
        .irq_o        (irq_o)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp({tag, " R2 raw"}, 32'(raw_o), 32'(m_raw));
        cmp({tag, " R6 masked"}, 32'(mask_word_o[2*N-1:N]), 32'(m_raw & ~m_mask));
        cmp({tag, " R7 mask"}, 32'(mask_word_o[N-1:0]), 32'(m_mask));
        cmp({tag, " R8 irq"}, 32'(irq_o), 32'(m_irq));
    endtask

    // one clock: inputs applied at falling edge, model advanced at rising edge
    task automatic step(input logic [N-1:0] lvl, input logic rd, input logic wr,
                        input logic [N-1:0] wd, input string tag);
        logic [N-1:0] rise;
        evt_lvl_i = lvl; raw_rd_i = rd; mask_wr_i = wr; mask_wdata_i = wd;
        @(posedge clk);
        rise   = lvl & ~m_prev;
        m_irq  = |(m_raw & ~m_mask);
        m_raw  = (rd ? '0 : m_raw) | rise;
        if (wr) m_mask = wd;
        m_prev = lvl;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1 raw", 32'(raw_o), 32'h01);
        cmp("R1 mask", 32'(mask_word_o[N-1:0]), 32'h3F);
        cmp("R1 masked", 32'(mask_word_o[2*N-1:N]), 32'h0);
        cmp("R1 irq", 32'(irq_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 post-release");

        // R3 bit positions: each event alone sets only its own bit
        step(6'h00, 1'b1, 1'b1, 6'h00, "R3 clear");
        for (int i = 0; i < N; i++) begin
            step(6'h00, 1'b1, 1'b0, 6'h00, "R3 idle");
            step(6'(1 << i), 1'b0, 1'b0, 6'h00, "R3 single");
            cmp("R3 position", 32'(raw_o), 32'(1 << i));
        end

        // R2 steady high does not re-set after clear
        step(6'h3F, 1'b1, 1'b0, 6'h00, "R2 rise");
        step(6'h3F, 1'b1, 1'b0, 6'h00, "R2 clear");
        step(6'h3F, 1'b0, 1'b0, 6'h00, "R2 steady");
        cmp("R2 no re-set", 32'(raw_o), 32'h0);

        // R5 rise coincident with clearing read
        step(6'h00, 1'b0, 1'b0, 6'h00, "R5 low");
        step(6'h24, 1'b0, 1'b0, 6'h00, "R5 set");
        step(6'h2C, 1'b1, 1'b0, 6'h00, "R5 coincide");
        cmp("R5 kept", 32'(raw_o), 32'h08);

        // R9 sticky through level fall and mask write
        step(6'h00, 1'b0, 1'b1, 6'h15, "R9 fall");
        step(6'h00, 1'b0, 1'b1, 6'h2A, "R9 mask");
        cmp("R9 sticky", 32'(raw_o), 32'h08);

        // R6 R7 R8 exhaustive mask sweep with all events raised
        for (int m = 0; m < 64; m++) begin
            step(6'h00, 1'b1, 1'b1, 6'(m), "R7 sweep wr");
            step(6'h3F, 1'b0, 1'b0, 6'(m), "R6 sweep rise");
            step(6'h3F, 1'b0, 1'b0, 6'(m), "R8 sweep irq");
            cmp("R6 sweep masked", 32'(mask_word_o[2*N-1:N]), 32'(~m & 6'h3F));
            cmp("R8 sweep irq", 32'(irq_o), 32'(m != 63));
        end

        // R4 R5 R9 free-running mixed stimulus
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[5:0], lfsr[7] & lfsr[8], lfsr[9] & lfsr[11] & lfsr[6],
                 lfsr[15:10], "R4 mixed");
        end

        finish_run();
    end
endmodule